// File: doc/BRIEF.md
# Four-Bank Command and Row Tracker

This block is the command front end of a double-data-rate memory interface. Each rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, along with a two-bit bank address and a 13-bit address bus. It decodes these into a one-cycle strobe for each command it accepts. It keeps a small state machine per bank that tracks whether a row is open and which row that is. It refuses commands that break the bank protocol and flags them.

A read or write with address bit 10 set asks for auto-precharge. The bank then stays open for the burst, precharges itself for a fixed number of cycles, and returns to idle with no further command. The starting column is taken from the address bus. Which bits form the column depends on a data-width parameter. A free-running interval counter raises a refresh request, and an accepted REFRESH command clears it.

The outputs are registered, so every effect of a command sampled at one edge appears right after that edge.

Top module: `bank_cmd_tracker`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n}: 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 REFRESH, 0000 MODE SET. The codes 0111 and 1xxx are no-ops. An accepted command raises its strobe for exactly the one cycle after the sampling edge, and at most one strobe is high at a time.
- R2: ACTIVE to an idle bank pulses act_stb, opens that bank, and loads addr[12:0] into its open_row slice (bank b at bits b*13 upward). Other banks keep their state.
- R3: READ or WRITE to an open bank with no burst pending pulses rd_stb or wr_stb and updates col_addr. PRECHARGE always pulses pre_stb. With addr[10]=0 it closes the addressed bank if that bank is open; with addr[10]=1 it closes every open bank.
- R4: READ or WRITE to a bank that is not open, or that has an auto-precharge burst pending, raises illegal for one cycle. It gives no strobe and leaves col_addr and all bank state unchanged.
- R5: ACTIVE to a bank that is not idle raises illegal for one cycle. It gives no strobe and leaves that bank's open_row unchanged.
- R6: col_addr is {addr[11],addr[9:0]} when WIDTH_SEL=0 (x4), {0,addr[9:0]} when WIDTH_SEL=1 (x8), and {00,addr[8:0]} when WIDTH_SEL=2 (x16).
- R7: READ or WRITE with addr[10]=1 to an open bank keeps bank_open high for BURST_CYC cycles. The bank then spends PRE_CYC cycles with both bank_open and bank_idle low, and then returns to idle. A bank is never open and idle at once.
- R8: REFRESH is accepted (ref_stb) only when all four banks are idle. Otherwise it raises illegal.
- R9: ref_req rises after every REF_CLKS clock edges counted from reset. It is cleared by an accepted REFRESH, and it stays set if the interval expires on the same edge.
- R10: During and right after reset all banks are idle, all strobes and illegal are low, col_addr, open_row and ref_req are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row / column address, bit 10 selects all-bank or auto-precharge |
| act_stb | output | 1 | ACTIVE accepted |
| rd_stb | output | 1 | READ accepted |
| wr_stb | output | 1 | WRITE accepted |
| pre_stb | output | 1 | PRECHARGE accepted |
| ref_stb | output | 1 | REFRESH accepted |
| mrs_stb | output | 1 | MODE SET accepted |
| illegal | output | 1 | Protocol violation seen |
| bank_open | output | 4 | Per-bank row open |
| bank_idle | output | 4 | Per-bank idle |
| open_row | output | 52 | Open row per bank, 13 bits each |
| col_addr | output | 11 | Start column of last accepted READ/WRITE |
| ref_req | output | 1 | Refresh due |

## Verification
The bench targets commands that arrive on the edge where a bank leaves its precharge countdown. A design off by one cycle there would accept an ACTIVE too early, or flag a legal one. It sends READ to a bank that is still bursting and ACTIVE to an open bank, and it checks that these change nothing. A design that updated state anyway would corrupt open_row or col_addr. It issues REFRESH with one bank busy and lets the refresh interval expire while REFRESH commands are flowing. A wrong priority between setting and clearing would drop a pending request. Three instances with different width settings catch a column slice that is wrong for one width.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE, B_OPEN, B_BURST, B_PRECH
  } bst_e;
endpackage

// File: rtl/bct_cmd_decode.sv
module bct_cmd_decode
  import bct_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/bct_bank_fsm.sv
module bct_bank_fsm
  import bct_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int BURST_CYC = 4,
  parameter int PRE_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  cmd_e             cmd,
  input  logic             a10,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic             idle_o,
  output logic             rw_ok_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int MAXC = (BURST_CYC > PRE_CYC) ? BURST_CYC : PRE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  bst_e             st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             row_en;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    row_en = 1'b0;
    case (st_q)
      B_IDLE:
        if (sel && cmd == C_ACT) begin
          st_d   = B_OPEN;
          row_en = 1'b1;
        end
      B_OPEN:
        if (cmd == C_PRE && (sel || a10)) begin
          st_d = B_IDLE;
        end else if (sel && a10 && (cmd == C_RD || cmd == C_WR)) begin
          st_d  = B_BURST;
          cnt_d = CW'(BURST_CYC - 1);
        end
      B_BURST:
        if (cnt_q == '0) begin
          st_d  = B_PRECH;
          cnt_d = CW'(PRE_CYC - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      B_PRECH:
        if (cnt_q == '0) st_d = B_IDLE;
        else             cnt_d = cnt_q - CW'(1);
      default: st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_in;
  end

  assign open_o  = (st_q == B_OPEN) || (st_q == B_BURST);
  assign idle_o  = (st_q == B_IDLE);
  assign rw_ok_o = (st_q == B_OPEN);
  assign row_o   = row_q;
endmodule

// File: rtl/bct_col_map.sv
module bct_col_map #(
  parameter int WIDTH_SEL = 0,
  parameter int COL_W     = 11
) (
  input  logic [COL_W-1:0] src,
  output logic [COL_W-1:0] col
);
  generate
    if (WIDTH_SEL == 0) begin : g_x4
      assign col = src;
    end else if (WIDTH_SEL == 1) begin : g_x8
      assign col = {1'b0, src[COL_W-2:0]};
    end else begin : g_x16
      assign col = {2'b00, src[COL_W-3:0]};
    end
  endgenerate
endmodule

// File: rtl/bct_ref_timer.sv
module bct_ref_timer #(
  parameter int REF_CLKS = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_acc,
  output logic ref_req
);
  localparam int TW = $clog2(REF_CLKS);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          expire;

  always_comb begin
    expire = (cnt_q == '0);
    cnt_d  = expire ? TW'(REF_CLKS - 1) : cnt_q - TW'(1);
    if (expire)       req_d = 1'b1;
    else if (ref_acc) req_d = 1'b0;
    else              req_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TW'(REF_CLKS - 1);
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign ref_req = req_q;
endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bct_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int WIDTH_SEL = 0,
  parameter int BURST_CYC = 4,
  parameter int PRE_CYC   = 3,
  parameter int REF_CLKS  = 1562
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [BA_W-1:0]          ba,
  input  logic [ROW_W-1:0]         addr,
  output logic                     act_stb,
  output logic                     rd_stb,
  output logic                     wr_stb,
  output logic                     pre_stb,
  output logic                     ref_stb,
  output logic                     mrs_stb,
  output logic                     illegal,
  output logic [(1<<BA_W)-1:0]     bank_open,
  output logic [(1<<BA_W)-1:0]     bank_idle,
  output logic [(1<<BA_W)*ROW_W-1:0] open_row,
  output logic [10:0]              col_addr
  ,output logic                    ref_req
);
  localparam int NBANK = 1 << BA_W;
  localparam int COL_W = 11;

  cmd_e             cmd;
  logic [NBANK-1:0] rw_ok;
  logic [COL_W-1:0] col_w;
  logic             ok_act, ok_rd, ok_wr, ok_pre, ok_ref, ok_mrs, bad;
  logic             tgt_idle, tgt_rw, all_idle;

  bct_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      bct_bank_fsm #(
        .ROW_W(ROW_W), .BURST_CYC(BURST_CYC), .PRE_CYC(PRE_CYC)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ba == BA_W'(b)),
        .cmd    (cmd),
        .a10    (addr[10]),
        .row_in (addr),
        .open_o (bank_open[b]),
        .idle_o (bank_idle[b]),
        .rw_ok_o(rw_ok[b]),
        .row_o  (open_row[b*ROW_W +: ROW_W])
      );
    end
  endgenerate

  bct_col_map #(.WIDTH_SEL(WIDTH_SEL), .COL_W(COL_W)) u_col (
    .src({addr[11], addr[9:0]}),
    .col(col_w)
  );

  always_comb begin
    tgt_idle = bank_idle[ba];
    tgt_rw   = rw_ok[ba];
    all_idle = &bank_idle;
    ok_act   = (cmd == C_ACT) && tgt_idle;
    ok_rd    = (cmd == C_RD)  && tgt_rw;
    ok_wr    = (cmd == C_WR)  && tgt_rw;
    ok_pre   = (cmd == C_PRE);
    ok_ref   = (cmd == C_REF) && all_idle;
    ok_mrs   = (cmd == C_MRS);
    bad      = ((cmd == C_ACT) && !tgt_idle)
            || ((cmd == C_RD || cmd == C_WR) && !tgt_rw)
            || ((cmd == C_REF) && !all_idle);
  end

  bct_ref_timer #(.REF_CLKS(REF_CLKS)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_acc(ok_ref), .ref_req(ref_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_stb <= 1'b0;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      pre_stb <= 1'b0;
      ref_stb <= 1'b0;
      mrs_stb <= 1'b0;
      illegal <= 1'b0;
    end else begin
      act_stb <= ok_act;
      rd_stb  <= ok_rd;
      wr_stb  <= ok_wr;
      pre_stb <= ok_pre;
      ref_stb <= ok_ref;
      mrs_stb <= ok_mrs;
      illegal <= bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              col_addr <= '0;
    else if (ok_rd || ok_wr) col_addr <= col_w;
  end
endmodule

// File: rtl/bank_cmd_tracker_chk.sv
module bank_cmd_tracker_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_stb,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          pre_stb,
  input logic          ref_stb,
  input logic          mrs_stb,
  input logic          illegal,
  input logic [NB-1:0] bank_open,
  input logic [NB-1:0] bank_idle,
  input logic          ref_req
);
  p_one_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb}));

  p_open_needs_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bank_open & ~$past(bank_open))) |-> act_stb);

  p_bad_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(act_stb || rd_stb || wr_stb || ref_stb));

  p_idle_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_open & bank_idle) == '0);

  p_ref_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |-> (&$past(bank_idle)));

  p_req_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> ref_stb);
endmodule

bind bank_cmd_tracker bank_cmd_tracker_chk #(.NB(1 << BA_W)) u_chk (.*);

// File: tb/sim_bank_cmd_tracker.sv
`timescale 1ns/1ps
module sim_bank_cmd_tracker;
  localparam int BURST = 4;
  localparam int PREC  = 3;
  localparam int REFC  = 1562;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;

  logic act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, illegal, ref_req;
  logic [3:0]  bank_open, bank_idle;
  logic [51:0] open_row;
  logic [10:0] col0, col1, col2;
  logic [14:0] dummy1, dummy2;
  logic [3:0]  o1, i1, o2, i2;
  logic [51:0] r1, r2;
  logic        q1, q2;

  always #2.5 clk = ~clk;

  bank_cmd_tracker #(.WIDTH_SEL(0), .BURST_CYC(BURST), .PRE_CYC(PREC), .REF_CLKS(REFC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .pre_stb(pre_stb), .ref_stb(ref_stb), .mrs_stb(mrs_stb), .illegal(illegal),
    .bank_open(bank_open), .bank_idle(bank_idle), .open_row(open_row),
    .col_addr(col0), .ref_req(ref_req));

  bank_cmd_tracker #(.WIDTH_SEL(1), .BURST_CYC(BURST), .PRE_CYC(PREC), .REF_CLKS(REFC)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .act_stb(dummy1[0]), .rd_stb(dummy1[1]), .wr_stb(dummy1[2]),
    .pre_stb(dummy1[3]), .ref_stb(dummy1[4]), .mrs_stb(dummy1[5]), .illegal(dummy1[6]),
    .bank_open(o1), .bank_idle(i1), .open_row(r1), .col_addr(col1), .ref_req(q1));

  bank_cmd_tracker #(.WIDTH_SEL(2), .BURST_CYC(BURST), .PRE_CYC(PREC), .REF_CLKS(REFC)) u2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .act_stb(dummy2[0]), .rd_stb(dummy2[1]), .wr_stb(dummy2[2]),
    .pre_stb(dummy2[3]), .ref_stb(dummy2[4]), .mrs_stb(dummy2[5]), .illegal(dummy2[6]),
    .bank_open(o2), .bank_idle(i2), .open_row(r2), .col_addr(col2), .ref_req(q2));

  // behavioural reference: 0 idle, 1 open, 2 burst, 3 precharging
  int st[4];
  int cnt[4];
  logic [12:0] mrow[4];
  int refc;
  bit e_req, e_act, e_rd, e_wr, e_pre, e_ref, e_mrs, e_ill;
  logic [10:0] e_col[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin st[b] = 0; cnt[b] = 0; mrow[b] = '0; end
      refc = REFC - 1; e_req = 0;
      {e_act, e_rd, e_wr, e_pre, e_ref, e_mrs, e_ill} = '0;
      for (int w = 0; w < 3; w++) e_col[w] = '0;
    end else begin
      int c; int ps[4]; bit allidle; bit expire;
      c = 0;
      if (!cs_n) begin
        case ({ras_n, cas_n, we_n})
          3'b011: c = 1; 3'b101: c = 2; 3'b100: c = 3;
          3'b010: c = 4; 3'b001: c = 5; 3'b000: c = 6;
          default: c = 0;
        endcase
      end
      allidle = 1;
      for (int b = 0; b < 4; b++) begin ps[b] = st[b]; if (st[b] != 0) allidle = 0; end
      e_act = (c == 1) && ps[ba] == 0;
      e_rd  = (c == 2) && ps[ba] == 1;
      e_wr  = (c == 3) && ps[ba] == 1;
      e_pre = (c == 4);
      e_ref = (c == 5) && allidle;
      e_mrs = (c == 6);
      e_ill = ((c == 1) && ps[ba] != 0) || ((c == 2 || c == 3) && ps[ba] != 1) ||
              ((c == 5) && !allidle);
      if (e_rd || e_wr) begin
        e_col[0] = {addr[11], addr[9:0]};
        e_col[1] = {1'b0, addr[9:0]};
        e_col[2] = {2'b00, addr[8:0]};
      end
      for (int b = 0; b < 4; b++) begin
        if (ps[b] == 2) begin
          if (cnt[b] == 0) begin st[b] = 3; cnt[b] = PREC - 1; end else cnt[b]--;
        end else if (ps[b] == 3) begin
          if (cnt[b] == 0) st[b] = 0; else cnt[b]--;
        end else if (ps[b] == 0) begin
          if (c == 1 && ba == b[1:0]) begin st[b] = 1; mrow[b] = addr; end
        end else begin
          if (c == 4 && (ba == b[1:0] || addr[10])) st[b] = 0;
          else if ((c == 2 || c == 3) && ba == b[1:0] && addr[10]) begin
            st[b] = 2; cnt[b] = BURST - 1;
          end
        end
      end
      expire = (refc == 0);
      if (expire) begin e_req = 1; refc = REFC - 1; end
      else begin refc--; if (e_ref) e_req = 0; end
    end
  end

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] eo, ei;
      for (int b = 0; b < 4; b++) begin
        eo[b] = (st[b] == 1 || st[b] == 2);
        ei[b] = (st[b] == 0);
        chk("R2", "open_row", open_row[b*13 +: 13], mrow[b]);
      end
      if (!rst_n) chk("R10", "reset idle", bank_idle, 4'hf);
      chk("R2", "act_stb", act_stb, e_act);
      chk("R3", "rd_stb", rd_stb, e_rd);
      chk("R3", "wr_stb", wr_stb, e_wr);
      chk("R3", "pre_stb", pre_stb, e_pre);
      chk("R8", "ref_stb", ref_stb, e_ref);
      chk("R1", "mrs_stb", mrs_stb, e_mrs);
      chk("R4", "illegal", illegal, e_ill);
      chk("R7", "bank_open", bank_open, eo);
      chk("R7", "bank_idle", bank_idle, ei);
      chk("R6", "col x4", col0, e_col[0]);
      chk("R6", "col x8", col1, e_col[1]);
      chk("R6", "col x16", col2, e_col[2]);
      chk("R9", "ref_req", ref_req, e_req);
    end
  end

  task automatic drive(input logic [3:0] code, input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = code;
    ba = b; addr = a;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) drive(4'b0111, 2'd0, 13'd0);
  endtask

  localparam logic [3:0] ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010,
                         REF = 4'b0001, MRS = 4'b0000, NOP = 4'b0111, DES = 4'b1111;

  initial begin
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = '0; addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2: open two banks, R5: re-open is refused
    drive(ACT, 2'd0, 13'h1abc);
    drive(ACT, 2'd0, 13'h0123);
    drive(RD, 2'd1, 13'h0005);          // R4: bank 1 idle
    drive(ACT, 2'd1, 13'h0f0f);
    drive(RD, 2'd0, 13'h0bff);          // R6: bit 11 set, bit 10 clear
    drive(WR, 2'd1, 13'h01aa);
    drive(REF, 2'd0, 13'h0000);         // R8: banks open
    drive(PRE, 2'd0, 13'h0000);
    drive(PRE, 2'd2, 13'h0400);         // all banks
    drive(REF, 2'd0, 13'h0000);         // R8: accepted
    drive(MRS, 2'd3, 13'h0033);
    drive(DES, 2'd2, 13'h1fff);
    // R7: auto-precharge, ACTIVE during busy window
    drive(ACT, 2'd2, 13'h0777);
    drive(WR, 2'd2, 13'h0455);
    drive(RD, 2'd2, 13'h0001);          // R4: burst pending
    for (int i = 0; i < BURST + PREC + 1; i++) drive(ACT, 2'd2, 13'h0a0a);
    drive(PRE, 2'd2, 13'h0400);
    idle_n(2);
    // random traffic, long enough to see R9 expire twice
    for (int i = 0; i < 3600; i++) begin
      int r;
      logic [3:0] code;
      r = int'($urandom % 20);
      case (r)
        0, 1, 2: code = ACT;
        3, 4, 5: code = RD;
        6, 7:    code = WR;
        8, 9:    code = PRE;
        10:      code = REF;
        11:      code = MRS;
        12:      code = DES;
        default: code = NOP;
      endcase
      drive(code, 2'($urandom), 13'($urandom));
    end
    idle_n(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule